// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block adds a memory-descriptor path to a configuration item port. A host writes the physical address of a 16-byte descriptor into a 64-bit address register. The register holds its value with the most significant byte at the lowest address. Writing the upper half (byte offset 0) only stores it. Writing the lower half (byte offset 4) starts an operation, so a descriptor below 4 GiB needs only one write. The register reads back a fixed 64-bit ASCII magic value, which software uses to detect the engine.

Once started, the engine reads the descriptor as four single-beat 32-bit words. The descriptor holds a 32-bit control word, a 32-bit length and a 64-bit target address, each big-endian. The control word can ask the engine to switch the item port to a new key. It can then copy bytes from the current item to memory one byte at a time, or move the item offset forward without copying. In every case the engine ends by writing a 32-bit status over the control word. The status is zero on success and has bit 0 set on failure. The item store is outside this block and is reached through the item port.

The memory master uses a valid/ready request channel. Once `mem_req_valid` is high, the request and all its fields stay fixed until the cycle in which `mem_req_ready` is also high. Each accepted request gets exactly one response, `mem_rsp_valid` for one cycle, no earlier than the cycle after acceptance. The engine always accepts responses and has at most one request outstanding. On the data buses, byte lane k (bits 8k+7:8k) carries the byte at address+k. A byte write carries its byte in lane 0.

Top module: `cfg_dma_top`

## Requirements
- R1: After reset the engine is idle: `busy` is 0, no memory request is raised, and no item-port pulse is driven; while idle it stays that way.
- R2: A host write with `host_wr_lo`=1 while idle starts an operation at the address {stored upper half, lower half}. A prior write with `host_wr_lo`=0 supplies the upper half. Each half is big-endian on `host_wr_data` (lane 0 is its most significant byte).
- R3: The descriptor is fetched as four 32-bit reads at A, A+4, A+8 and A+12. The fields are control, length, target[63:32] and target[31:0], each big-endian (the byte at the lowest address is most significant).
- R4: If control bit 3 (select) is set, one `item_sel` pulse carrying control[31:16] on `item_key` is issued before any data moves.
- R5: If control bit 1 (read) is set, length byte writes go to target+0 … target+length−1 in increasing order. Each carries the current item byte. A successful response to each write is followed by one `item_step` pulse. A length of 0 moves nothing.
- R6: If control bit 2 (skip) is set and bit 1 is clear, one `item_skip` pulse is issued with a length clamped to the bytes remaining, and no memory write is made.
- R7: Every operation ends with one 32-bit write to A. The write carries 32'h0000_0000 on success. On failure it carries big-endian value 1, which is bus data 32'h0100_0000.
- R8: The operation fails, with no data written, when a select names a key the item port rejects, or when a read length exceeds `item_remain`. It also fails, stopping the copy, on any memory error response.
- R9: After an operation the address register is 0 again, so a following write with `host_wr_lo`=1 alone forms a 32-bit address.
- R10: Host writes of either half while `busy` is 1 are ignored. They neither start an operation nor change the stored upper half.
- R11: `reg_rd_data` always shows the magic parameter in big-endian byte order (lane 0 = its most significant byte).
- R12: A memory request held while `mem_req_ready` is 0 keeps its valid, kind, address and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_valid | input | 1 | Host write to the address register |
| host_wr_lo | input | 1 | 1 = lower half (offset 4, starts), 0 = upper half (offset 0) |
| host_wr_data | input | 32 | Half-register data, big-endian by lane |
| reg_rd_data | output | 64 | Read value of the address register (magic) |
| busy | output | 1 | Operation in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted when high with valid |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_word | output | 1 | 1 = 32-bit access, 0 = byte access |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 32 | Write data (byte writes use lane 0) |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_err | input | 1 | Response reports an error |
| mem_rsp_data | input | 32 | Read data |
| item_sel | output | 1 | Select pulse; resets the item offset |
| item_key | output | 16 | Key for the select pulse |
| item_sel_ok | input | 1 | The key on `item_key` is valid |
| item_remain | input | 32 | Bytes left from the current offset |
| item_rd_data | input | 8 | Item byte at the current offset |
| item_step | output | 1 | Advance the item offset by one byte |
| item_skip | output | 1 | Advance the item offset by `item_skip_len` |
| item_skip_len | output | 32 | Clamped skip distance |

## Verification
The bench goes after the byte order of the register halves and the descriptor fields. A design that failed to swap bytes would fetch from, and write to, scrambled addresses, and the scoreboard would flag every transaction. It then checks the upper-half register in two cases. If the register were not cleared after an operation, a later single lower write would land above 4 GiB. If it took writes while busy, a mid-operation write would redirect the next operation. It also covers reads longer than the item, invalid keys and memory errors in the middle of a copy. A design that stopped late would emit stray byte writes, and one that got the status encoding wrong would report success. It further covers skips past the end and zero-length reads, where an unclamped offset or a spurious write would show. Throughout, the memory's ready signal drops at irregular points to test that requests hold steady.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam int CTL_ERR  = 0;
  localparam int CTL_RD   = 1;
  localparam int CTL_SKIP = 2;
  localparam int CTL_SEL  = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FREQ, ST_FRSP, ST_SEL, ST_ACT,
    ST_WREQ, ST_WRSP, ST_SREQ, ST_SRSP
  } dma_state_e;

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [63:0] bswap64(input logic [63:0] v);
    return {bswap32(v[31:0]), bswap32(v[63:32])};
  endfunction
endpackage

// File: rtl/cfg_dma_addr_reg.sv
module cfg_dma_addr_reg #(
  parameter logic [63:0] MAGIC = 64'h4346_475F_444D_4121,
  parameter int          HW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr_valid,
  input  logic            host_wr_lo,
  input  logic [HW-1:0]   host_wr_data,
  input  logic            busy,
  input  logic            done,
  output logic            trig,
  output logic [2*HW-1:0] trig_addr,
  output logic [2*HW-1:0] reg_rd_data
);
  import cfg_dma_pkg::*;

  logic [HW-1:0] hi_q;

  assign trig        = host_wr_valid && host_wr_lo && !busy;
  assign trig_addr   = {hi_q, bswap32(host_wr_data)};
  assign reg_rd_data = bswap64(MAGIC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  hi_q <= '0;
    else if (done)                               hi_q <= '0;
    else if (host_wr_valid && !host_wr_lo && !busy) hi_q <= bswap32(host_wr_data);
  end
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter int AW  = 64,
  parameter int LW  = 32,
  parameter int KW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [AW-1:0] trig_addr,
  output logic          busy,
  output logic          done,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic          mem_req_word,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_err,
  input  logic [31:0]   mem_rsp_data,
  output logic          item_sel,
  output logic [KW-1:0] item_key,
  input  logic          item_sel_ok,
  input  logic [LW-1:0] item_remain,
  input  logic [7:0]    item_rd_data,
  output logic          item_step,
  output logic          item_skip,
  output logic [LW-1:0] item_skip_len
);
  import cfg_dma_pkg::*;

  localparam int WORDS = 4;
  localparam int WIW   = $clog2(WORDS);

  dma_state_e     st_q;
  logic [AW-1:0]  desc_q, tgt_q;
  logic [31:0]    ctl_q;
  logic [LW-1:0]  len_q, cnt_q;
  logic [WIW-1:0] widx_q;
  logic           err_q;
  logic [31:0]    rsp_be;

  assign rsp_be        = bswap32(mem_rsp_data);
  assign busy          = (st_q != ST_IDLE);
  assign done          = (st_q == ST_SRSP) && mem_rsp_valid;
  assign item_key      = ctl_q[31:32-KW];
  assign item_sel      = (st_q == ST_SEL) && ctl_q[CTL_SEL];
  assign item_skip     = (st_q == ST_ACT) && !ctl_q[CTL_RD] && ctl_q[CTL_SKIP];
  assign item_skip_len = (len_q < item_remain) ? len_q : item_remain;
  assign item_step     = (st_q == ST_WRSP) && mem_rsp_valid && !mem_rsp_err;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_word  = 1'b1;
    mem_req_addr  = desc_q;
    mem_req_wdata = '0;
    unique case (st_q)
      ST_FREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = desc_q + AW'({widx_q, 2'b00});
      end
      ST_WREQ: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_word  = 1'b0;
        mem_req_addr  = tgt_q + AW'(cnt_q);
        mem_req_wdata = {24'b0, item_rd_data};
      end
      ST_SREQ: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_wdata = bswap32({31'b0, err_q});
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      desc_q <= '0;
      tgt_q  <= '0;
      ctl_q  <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      widx_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (trig) begin
          desc_q <= trig_addr;
          widx_q <= '0;
          err_q  <= 1'b0;
          st_q   <= ST_FREQ;
        end
        ST_FREQ: if (mem_req_ready) st_q <= ST_FRSP;
        ST_FRSP: if (mem_rsp_valid) begin
          case (widx_q)
            2'd0:    ctl_q          <= rsp_be;
            2'd1:    len_q          <= rsp_be[LW-1:0];
            2'd2:    tgt_q[63:32]   <= rsp_be;
            default: tgt_q[31:0]    <= rsp_be;
          endcase
          if (mem_rsp_err) begin
            err_q <= 1'b1;
            st_q  <= ST_SREQ;
          end else if (widx_q == WIW'(WORDS-1)) begin
            st_q <= ST_SEL;
          end else begin
            widx_q <= widx_q + 1'b1;
            st_q   <= ST_FREQ;
          end
        end
        ST_SEL: begin
          if (ctl_q[CTL_SEL] && !item_sel_ok) begin
            err_q <= 1'b1;
            st_q  <= ST_SREQ;
          end else begin
            st_q <= ST_ACT;
          end
        end
        ST_ACT: begin
          cnt_q <= '0;
          if (ctl_q[CTL_RD] && (len_q > item_remain)) begin
            err_q <= 1'b1;
            st_q  <= ST_SREQ;
          end else if (ctl_q[CTL_RD] && (len_q != '0)) begin
            st_q <= ST_WREQ;
          end else begin
            st_q <= ST_SREQ;
          end
        end
        ST_WREQ: if (mem_req_ready) st_q <= ST_WRSP;
        ST_WRSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            err_q <= 1'b1;
            st_q  <= ST_SREQ;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            st_q  <= (cnt_q + 1'b1 == len_q) ? ST_SREQ : ST_WREQ;
          end
        end
        ST_SREQ: if (mem_req_ready) st_q <= ST_SRSP;
        ST_SRSP: if (mem_rsp_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dma_top.sv
module cfg_dma_top #(
  parameter logic [63:0] MAGIC = 64'h4346_475F_444D_4121,
  parameter int          LW    = 32,
  parameter int          KW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_valid,
  input  logic          host_wr_lo,
  input  logic [31:0]   host_wr_data,
  output logic [63:0]   reg_rd_data,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic          mem_req_word,
  output logic [63:0]   mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_err,
  input  logic [31:0]   mem_rsp_data,
  output logic          item_sel,
  output logic [KW-1:0] item_key,
  input  logic          item_sel_ok,
  input  logic [LW-1:0] item_remain,
  input  logic [7:0]    item_rd_data,
  output logic          item_step,
  output logic          item_skip,
  output logic [LW-1:0] item_skip_len
);
  logic        trig, done;
  logic [63:0] trig_addr;

  cfg_dma_addr_reg #(.MAGIC(MAGIC), .HW(32)) u_areg (
    .clk, .rst_n, .host_wr_valid, .host_wr_lo, .host_wr_data,
    .busy, .done, .trig, .trig_addr, .reg_rd_data
  );

  cfg_dma_engine #(.AW(64), .LW(LW), .KW(KW)) u_eng (
    .clk, .rst_n, .trig, .trig_addr, .busy, .done,
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_word,
    .mem_req_addr, .mem_req_wdata, .mem_rsp_valid, .mem_rsp_err,
    .mem_rsp_data, .item_sel, .item_key, .item_sel_ok, .item_remain,
    .item_rd_data, .item_step, .item_skip, .item_skip_len
  );
endmodule

// File: rtl/cfg_dma_checker.sv
module cfg_dma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_we,
  input logic        mem_req_word,
  input logic [63:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        mem_rsp_valid,
  input logic        mem_rsp_err,
  input logic        item_sel,
  input logic        item_step,
  input logic        item_skip
);
  // R12: a stalled request keeps all its fields
  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_word) && $stable(mem_req_addr) && $stable(mem_req_wdata));

  // R1: idle means no traffic on either port
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !item_sel && !item_step && !item_skip);

  // R3: all reads are word-sized descriptor fetches
  a_r3_reads_are_words: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_we |-> mem_req_word);

  // R5: the offset steps only on a good write response
  a_r5_step_on_good_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    item_step |-> mem_rsp_valid && !mem_rsp_err);

  // R6: a skip moves no data and coincides with no other item action
  a_r6_skip_alone: assert property (@(posedge clk) disable iff (!rst_n)
    item_skip |-> !item_step && !item_sel && !mem_req_valid);

  // R4: select is a single-cycle pulse
  a_r4_sel_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    item_sel |=> !item_sel);
endmodule

bind cfg_dma_top cfg_dma_checker u_chk (
  .clk, .rst_n, .busy, .mem_req_valid, .mem_req_ready, .mem_req_we,
  .mem_req_word, .mem_req_addr, .mem_req_wdata, .mem_rsp_valid,
  .mem_rsp_err, .item_sel, .item_step, .item_skip
);

// File: tb/cfg_dma_top_tb.sv
module cfg_dma_top_tb;
  typedef struct packed {
    logic        we;
    logic        word;
    logic [63:0] addr;
    logic [31:0] data;
    logic [7:0]  req;
  } txn_t;

  logic        clk = 0, rst_n = 0;
  logic        host_wr_valid = 0, host_wr_lo = 0;
  logic [31:0] host_wr_data = 0;
  logic [63:0] reg_rd_data;
  logic        busy;
  logic        mem_req_valid, mem_req_we, mem_req_word;
  logic        mem_req_ready = 0;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        item_sel, item_step, item_skip, item_sel_ok;
  logic [15:0] item_key;
  logic [31:0] item_remain, item_skip_len;
  logic [7:0]  item_rd_data;

  int checks = 0, fails = 0;
  txn_t q[$];
  logic [7:0] mem [logic [63:0]];
  logic [15:0] cur_key;
  logic [31:0] cur_off;
  logic [15:0] ek;
  logic [31:0] eo;

  always #5 clk = ~clk;

  cfg_dma_top u_dut (.*);

  function automatic logic [31:0] bs(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
  function automatic logic [31:0] isz(input logic [15:0] k);
    case (k)
      16'd0: return 32'd6;
      16'd1: return 32'd12;
      16'd2: return 32'd3;
      default: return 32'd40;
    endcase
  endfunction
  function automatic logic [7:0] ibyte(input logic [15:0] k, input logic [31:0] o);
    return 8'(k * 29 + o * 3 + 1);
  endfunction
  function automatic logic bad_region(input logic [63:0] a);
    return a[63:60] == 4'hE;
  endfunction

  // item store model
  assign item_sel_ok  = item_key < 16'd4;
  assign item_remain  = isz(cur_key) - cur_off;
  assign item_rd_data = ibyte(cur_key, cur_off);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_key <= 0; cur_off <= 0;
    end else if (item_sel && item_sel_ok) begin
      cur_key <= item_key; cur_off <= 0;
    end else if (item_step) cur_off <= cur_off + 1;
    else if (item_skip)     cur_off <= cur_off + item_skip_len;
  end

  task automatic check(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  int rdy_cnt = 0;
  bit pend = 0;
  logic [31:0] pend_data;
  logic        pend_err;
  always @(negedge clk) begin
    mem_rsp_valid = 0;
    mem_rsp_err   = 0;
    if (pend) begin
      mem_rsp_valid = 1; mem_rsp_data = pend_data; mem_rsp_err = pend_err; pend = 0;
    end
    rdy_cnt++;
    mem_req_ready = rst_n && ((rdy_cnt % 5) != 2) && ((rdy_cnt % 7) != 4);
    if (mem_req_valid && mem_req_ready) begin
      pend = 1;
      pend_err = bad_region(mem_req_addr);
      pend_data = 0;
      if (!mem_req_we)
        for (int i = 0; i < 4; i++)
          pend_data[8*i +: 8] = mem.exists(mem_req_addr + 64'(i)) ? mem[mem_req_addr + 64'(i)] : 8'h00;
      if (q.size() == 0) begin
        check(0, "R2/R10 unexpected request", mem_req_addr, 0);
      end else begin
        txn_t e;
        logic [31:0] msk;
        e = q.pop_front();
        msk = e.word ? 32'hFFFF_FFFF : 32'h0000_00FF;
        check(mem_req_we == e.we && mem_req_word == e.word && mem_req_addr == e.addr,
              $sformatf("R%0d request kind/addr", e.req), {mem_req_we, mem_req_word, mem_req_addr[61:0]},
              {e.we, e.word, e.addr[61:0]});
        if (e.we)
          check((mem_req_wdata & msk) == e.data, $sformatf("R%0d write data", e.req),
                64'(mem_req_wdata & msk), 64'(e.data));
      end
    end
  end

  task automatic put_desc(input logic [63:0] d, input logic [31:0] ctl,
                          input logic [31:0] len, input logic [63:0] tgt);
    for (int i = 0; i < 4; i++) begin
      mem[d + 64'(i)]      = ctl[31-8*i -: 8];
      mem[d + 64'(4 + i)]  = len[31-8*i -: 8];
      mem[d + 64'(8 + i)]  = tgt[63-8*i -: 8];
      mem[d + 64'(12 + i)] = tgt[31-8*i -: 8];
    end
  endtask

  task automatic hw(input bit lo, input logic [31:0] v);
    @(negedge clk);
    host_wr_valid = 1; host_wr_lo = lo; host_wr_data = bs(v);
    @(negedge clk);
    host_wr_valid = 0;
  endtask

  // driver: build the descriptor, push expectations, trigger
  task automatic start_op(input logic [63:0] d, input bit use_hi, input logic [31:0] ctl,
                          input logic [31:0] len, input logic [63:0] tgt);
    bit err = 0;
    put_desc(d, ctl, len, tgt);
    for (int i = 0; i < 4; i++) q.push_back('{1'b0, 1'b1, d + 64'(4*i), 32'h0, 8'd3}); // R3
    if (ctl[3]) begin // R4
      if (ctl[31:16] >= 16'd4) err = 1; // R8
      else begin ek = ctl[31:16]; eo = 0; end
    end
    if (!err && ctl[1]) begin // R5
      if (len > isz(ek) - eo) err = 1;
      else for (int i = 0; i < int'(len); i++) begin
        q.push_back('{1'b1, 1'b0, tgt + 64'(i), {24'h0, ibyte(ek, eo)}, 8'd5});
        if (bad_region(tgt + 64'(i))) begin err = 1; break; end
        eo++;
      end
    end else if (!err && ctl[2]) begin // R6
      eo = eo + ((len < isz(ek) - eo) ? len : isz(ek) - eo);
    end
    q.push_back('{1'b1, 1'b1, d, err ? 32'h0100_0000 : 32'h0, 8'd7}); // R7
    if (use_hi) hw(0, d[63:32]);
    hw(1, d[31:0]);
  endtask

  task automatic finish_op(input string r);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q.size() == 0, {r, " all expected transactions seen"}, q.size(), 0);
    check(cur_key == ek, {r, " item key"}, cur_key, ek);
    check(cur_off == eo, {r, " item offset"}, cur_off, eo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ek = 0; eo = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(mem_req_valid == 0, "R1 no request after reset", mem_req_valid, 0);
    // R11: magic in big-endian lane order
    check(reg_rd_data[7:0] == 8'h43 && reg_rd_data[63:56] == 8'h21, "R11 magic",
          reg_rd_data, 64'h2141_4D44_5F47_4643);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(busy == 0 && mem_req_valid == 0, "R1 idle after release", busy, 0);

    // R2 R4 R5: select key 1, copy 5 bytes, 32-bit descriptor address
    start_op(64'h1000, 0, 32'h0001_000A, 5, 64'h2000);
    finish_op("R5 select+read");
    // R2: 64-bit descriptor and target, continue key 1 at offset 5
    start_op(64'h0000_0001_0000_3000, 1, 32'h0000_0002, 4, 64'h0000_0001_0000_4000);
    finish_op("R2 64-bit read");
    // R6: select key 3, skip 10 then read 2
    start_op(64'h1100, 0, 32'h0003_000C, 10, 64'h9999);
    finish_op("R6 skip");
    start_op(64'h1200, 0, 32'h0000_0002, 2, 64'h2100);
    finish_op("R5 read after skip");
    // R6: skip past the end clamps
    start_op(64'h1300, 0, 32'h0000_0004, 100, 64'h0);
    finish_op("R6 skip clamp");
    // R5: zero-length read
    start_op(64'h1400, 0, 32'h0001_000A, 0, 64'h2200);
    finish_op("R5 zero length");
    // R8: over-length read on key 2
    start_op(64'h1500, 0, 32'h0002_000A, 4, 64'h2300);
    finish_op("R8 over-length");
    // R8: invalid key
    start_op(64'h1600, 0, 32'h0005_000A, 1, 64'h2400);
    finish_op("R8 bad key");
    // R8: memory error during copy
    start_op(64'h1700, 0, 32'h0000_000A, 3, 64'hE000_0000_0000_0010);
    finish_op("R8 memory error");
    // R10: writes while busy are ignored
    start_op(64'h5000, 0, 32'h0001_000A, 3, 64'h2500);
    hw(0, 32'h7);
    hw(1, 32'h6000);
    check(busy == 1, "R10 still busy on first op", busy, 1);
    finish_op("R10 ignored writes");
    repeat (20) @(negedge clk);
    check(busy == 0, "R10 no second op started", busy, 0);
    // R9: upper half is zero, single lower write gives 32-bit address
    start_op(64'h7000, 0, 32'h0000_0002, 1, 64'h2600);
    finish_op("R9 cleared upper half");

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule